// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block narrows a 32-bit single-precision floating-point bit pattern to a 16-bit half-precision pattern in a single combinational pass. It is meant to sit on a datapath that stores or sends values in the smaller format, for example when packing shader outputs or filter coefficients. The output depends only on the present input. There is no clock, state or handshake.

Finite values are rebiased, and the mantissa is cut down by a fixed round-half-up rule that looks only at the first dropped bit. When the rounding carries, the result moves into the next binade. Magnitudes too large for the narrow format saturate to infinity. Magnitudes below the normal range become denormals, and magnitudes below the smallest denormal become a signed zero. Infinities pass through. NaNs always stay NaNs and fall into one of three groups: quiet NaNs, NaNs whose payload would truncate to nothing, and all other NaNs. The field widths of both formats are parameters. The defaults give the 8/23 to 5/10 conversion.

Top module: `sp_to_hp_conv`

## Requirements
- R1: Output bit 15 always equals input bit 31, for every class of input, including zeros and NaNs.
- R2: For a finite input with exponent field e (bits 30:23) where 113 <= e <= 142 and mantissa bit 12 clear, the output exponent field (bits 14:10) is e-112 and the output mantissa (bits 9:0) is input mantissa bits 22:13.
- R3: Rounding for normal results depends only on input mantissa bit 12. When bit 12 is set, one is added to the truncated 10-bit mantissa. Input mantissa bits 11:0 have no effect on the result.
- R4: When that increment overflows the 10-bit mantissa, the output mantissa becomes zero and the output exponent rises by one. For example, 0x3FFFF000 gives 0x4000.
- R5: A finite input whose rebiased exponent is above 30, or equals 30 with a rounding carry, gives 0x7C00 with the input sign. The largest finite result is 0x7BFF (from 0x477FE000).
- R6: For a finite input with 103 <= e <= 112, the output magnitude is (2^23 + mantissa + 0x2000·bit12) shifted right by (126 - e). This gives denormals down to 0x0001 (from 0x33800000). A carry out of the denormal range yields 0x0400.
- R7: Inputs with e = 0, and finite inputs too small for the smallest denormal, give a signed zero (0x0000 or 0x8000).
- R8: An input infinity (e = 255, mantissa zero) gives 0x7C00 with the input sign.
- R9: An input NaN with mantissa bit 22 set (mantissa above 0x3FFFFF) gives 0x7E00 with the input sign, whatever its payload.
- R10: An input NaN with bit 22 clear and mantissa bits 21:13 all zero gives 0x7C01 with the input sign, so the result remains a NaN.
- R11: Any other input NaN gives exponent field 31 and mantissa equal to input mantissa bits 22:13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sp_bits_i | input | 32 | Single-precision bit pattern: sign 31, exponent 30:23, mantissa 22:0 |
| hp_bits_o | output | 16 | Half-precision bit pattern: sign 15, exponent 14:10, mantissa 9:0 |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and 23-bit mantissa in, a 5-bit exponent and 10-bit mantissa out. At these widths every one of the 256 input exponents can be swept with both signs. Each exponent is paired with a fixed set of mantissas: rounding-boundary values around bit 12, all-ones and carry-producing patterns, NaN-class edges around bit 22 and bits 21:13, and pseudo-random fill. This full exponent sweep covers every transition: saturation, the normal range, the denormal ramp, the flush to zero, and the special exponent. Each result is compared with an integer model in the bench. Directed vectors fix the named corner values.

// File: rtl/s2h_pkg.sv
package s2h_pkg;

   // Exponent bias of a binary interchange-style format with ew exponent bits.
   function automatic int bias_of(input int ew);
      return (1 << (ew - 1)) - 1;
   endfunction

   // Largest exponent code that still encodes a finite number.
   function automatic int max_finite_exp(input int ew);
      return (1 << ew) - 2;
   endfunction

endpackage

// File: rtl/s2h_field_split.sv
module s2h_field_split #(
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23
) (
   input  logic [SRC_EXP+SRC_MAN:0] bits_i,
   output logic                     sign_o,
   output logic [SRC_EXP-1:0]       exp_o,
   output logic [SRC_MAN-1:0]       man_o,
   output logic                     exp_top_o
);
   localparam int SW = SRC_EXP + SRC_MAN + 1;

   assign sign_o    = bits_i[SW-1];
   assign exp_o     = bits_i[SW-2 -: SRC_EXP];
   assign man_o     = bits_i[SRC_MAN-1:0];
   // all-ones exponent marks infinity / NaN
   assign exp_top_o = &exp_o;
endmodule

// File: rtl/s2h_finite_path.sv
module s2h_finite_path
   import s2h_pkg::*;
#(
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10
) (
   input  logic [SRC_EXP-1:0]         exp_i,
   input  logic [SRC_MAN-1:0]         man_i,
   output logic [DST_EXP+DST_MAN-1:0] mag_o
);
   localparam int SH    = SRC_MAN - DST_MAN;            // dropped mantissa bits
   localparam int OFF   = bias_of(SRC_EXP) - bias_of(DST_EXP);
   localparam int EW    = SRC_EXP + 2;                  // signed rebiased width
   localparam int EMAXF = max_finite_exp(DST_EXP);
   localparam int MW    = DST_EXP + DST_MAN;
   localparam int SIGW  = SRC_MAN + 2;                  // carry + hidden + mantissa
   localparam logic signed [EW-1:0] OFF_S = EW'(OFF);

   logic signed [EW-1:0] erb;
   logic                 rnd;
   logic [SRC_MAN:0]     man_r;
   logic [MW-1:0]        norm_mag;
   logic [SIGW-1:0]      sig;
   logic [MW-1:0]        den_mag;
   int                   erb_i;
   int                   sa_i;

   assign erb   = $signed({2'b00, exp_i}) - OFF_S;
   assign erb_i = int'(erb);
   assign rnd   = man_i[SH-1];

   // normal path: round on the first dropped bit, carry folds into exponent
   assign man_r    = {1'b0, man_i} + ((SRC_MAN+1)'(rnd) << SH);
   assign norm_mag = {erb[DST_EXP-1:0], {DST_MAN{1'b0}}} + MW'(man_r[SRC_MAN:SH]);

   // denormal path: hidden bit restored, rounded, then shifted right
   assign sig  = {1'b0, (exp_i != '0), man_i} + (SIGW'(rnd) << SH);
   assign sa_i = SH + 1 - erb_i;

   always_comb begin
      if (sa_i >= SIGW) den_mag = '0;
      else              den_mag = MW'(sig >> sa_i);
   end

   always_comb begin
      if (erb_i > EMAXF)     mag_o = {{DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
      else if (erb_i >= 1)   mag_o = norm_mag;
      else                   mag_o = den_mag;
   end
endmodule

// File: rtl/s2h_special_path.sv
module s2h_special_path #(
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10
) (
   input  logic [SRC_MAN-1:0]         man_i,
   output logic [DST_EXP+DST_MAN-1:0] mag_o
);
   localparam int SH = SRC_MAN - DST_MAN;

   logic               quiet;
   logic [DST_MAN-1:0] trunc;

   assign quiet = man_i[SRC_MAN-1];
   assign trunc = man_i[SRC_MAN-1:SH];

   always_comb begin
      if (man_i == '0)
         mag_o = {{DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
      else if (quiet)
         mag_o = {{DST_EXP{1'b1}}, 1'b1, {(DST_MAN-1){1'b0}}};
      else if (trunc == '0)
         mag_o = {{DST_EXP{1'b1}}, DST_MAN'(1)};
      else
         mag_o = {{DST_EXP{1'b1}}, trunc};
   end
endmodule

// File: rtl/sp_to_hp_conv.sv
module sp_to_hp_conv #(
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10
) (
   input  logic [SRC_EXP+SRC_MAN:0] sp_bits_i,
   output logic [DST_EXP+DST_MAN:0] hp_bits_o
);
   localparam int MW = DST_EXP + DST_MAN;

   // elaboration-time parameter checks
   if (DST_MAN < 2 || DST_MAN >= SRC_MAN) begin : g_bad_man
      $error("sp_to_hp_conv: destination mantissa must be 2..SRC_MAN-1");
   end
   if (DST_EXP < 2 || DST_EXP >= SRC_EXP) begin : g_bad_exp
      $error("sp_to_hp_conv: destination exponent must be 2..SRC_EXP-1");
   end

   logic               sgn;
   logic [SRC_EXP-1:0] ex;
   logic [SRC_MAN-1:0] mn;
   logic               ex_top;
   logic [MW-1:0]      fin_mag;
   logic [MW-1:0]      spc_mag;

   s2h_field_split #(.SRC_EXP(SRC_EXP), .SRC_MAN(SRC_MAN)) split_i (
      .bits_i(sp_bits_i), .sign_o(sgn), .exp_o(ex), .man_o(mn), .exp_top_o(ex_top)
   );

   s2h_finite_path #(.SRC_EXP(SRC_EXP), .SRC_MAN(SRC_MAN),
                     .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)) fin_i (
      .exp_i(ex), .man_i(mn), .mag_o(fin_mag)
   );

   s2h_special_path #(.SRC_MAN(SRC_MAN), .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)) spc_i (
      .man_i(mn), .mag_o(spc_mag)
   );

   assign hp_bits_o = {sgn, ex_top ? spc_mag : fin_mag};
endmodule

// File: rtl/s2h_chk.sv
module s2h_chk #(
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10
) (
   input logic [SRC_EXP+SRC_MAN:0] sp_bits_i,
   input logic [DST_EXP+DST_MAN:0] hp_bits_o
);
   localparam int SW = SRC_EXP + SRC_MAN + 1;
   localparam int DW = DST_EXP + DST_MAN + 1;

   logic [SRC_EXP-1:0] ie;
   logic [SRC_MAN-1:0] im;
   logic [DST_EXP-1:0] oe;
   logic [DST_MAN-1:0] om;

   assign ie = sp_bits_i[SW-2 -: SRC_EXP];
   assign im = sp_bits_i[SRC_MAN-1:0];
   assign oe = hp_bits_o[DW-2 -: DST_EXP];
   assign om = hp_bits_o[DST_MAN-1:0];

   always_comb begin
      a_r1_sign: assert (hp_bits_o[DW-1] == sp_bits_i[SW-1])
         else $error("R1 sign not carried");
      if (ie == '0)
         a_r7_zero: assert (oe == '0 && om == '0)
            else $error("R7 zero/denormal input not flushed");
      if (&ie && im == '0)
         a_r8_inf: assert (&oe && om == '0)
            else $error("R8 infinity not kept");
      if (&ie && im[SRC_MAN-1])
         a_r9_quiet_code: assert (&oe && om == {1'b1, {(DST_MAN-1){1'b0}}})
            else $error("R9 quiet NaN code wrong");
      if (&ie && im != '0)
         a_r10_nan_stays_nan: assert (&oe && om != '0)
            else $error("R10 NaN lost");
      if (!(&ie))
         a_r5_finite_not_nan: assert (!(&oe) || om == '0)
            else $error("R5 finite input produced NaN");
   end
endmodule

bind sp_to_hp_conv s2h_chk #(
   .SRC_EXP(SRC_EXP), .SRC_MAN(SRC_MAN), .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)
) chk_i (
   .sp_bits_i(sp_bits_i), .hp_bits_o(hp_bits_o)
);

// File: tb/sp_to_hp_conv_tb_top.sv
module sp_to_hp_conv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] sp;
   logic [15:0] hp;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [22:0] mans [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_to_hp_conv dut_i (.sp_bits_i(sp), .hp_bits_o(hp));

   function automatic logic [15:0] ref_h(input logic [31:0] f);
      int e = int'(f[30:23]);
      int m = int'(f[22:0]);
      int q, ex, sa, r;
      logic [14:0] mag;
      if (e == 255) begin
         if (m == 0)                mag = 15'h7C00;
         else if (m >= 'h400000)    mag = 15'h7E00;
         else if ((m >> 13) == 0)   mag = 15'h7C01;
         else                       mag = 15'h7C00 | 15'(m >> 13);
      end else if (e == 0) begin
         mag = '0;
      end else begin
         ex = e - 112;
         if (ex >= 1) begin
            q = m >> 13;
            if ((m & 'h1000) != 0) q = q + 1;
            if (q == 1024) begin ex = ex + 1; q = 0; end
            if (ex >= 31) mag = 15'h7C00;
            else          mag = 15'(ex * 1024 + q);
         end else begin
            r  = m + 'h800000 + ((m >> 12) & 1) * 'h2000;
            sa = 14 - ex;
            mag = (sa > 30) ? 15'h0 : 15'(r >> sa);
         end
      end
      return {f[31], mag};
   endfunction

   function automatic string tag_of(input logic [31:0] f);
      int e = int'(f[30:23]);
      if (e == 255) begin
         if (f[22:0] == 0)        return "R8";
         if (f[22])               return "R9";
         if (f[21:13] == 0)       return "R10";
         return "R11";
      end
      if (e == 0)   return "R7";
      if (e > 142)  return "R5";
      if (e <= 112) return "R6";
      if (f[12])    return "R3";
      return "R2";
   endfunction

   task automatic check(input logic [31:0] f, input logic [15:0] expv, input string tag);
      @(posedge clk);
      #1 sp = f;
      @(negedge clk);
      n_run++;
      if (hp !== expv) begin
         n_fail++;
         $display("FAIL %s in=%h got=%h expected=%h", tag, f, hp, expv);
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired got=hang expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg;
      sp = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_run++;
      if (hp !== 16'h0000) begin
         n_fail++;
         $display("FAIL R7 reset-time zero got=%h expected=0000", hp);
      end
      rst_n = 1'b1;

      // directed corners
      check(32'h3F800000, 16'h3C00, "R2 one");
      check(32'hC0000000, 16'hC000, "R1 R2 minus two");
      check(32'h3F801000, 16'h3C01, "R3 round up on bit12");
      check(32'h3F800FFF, 16'h3C00, "R3 low bits ignored");
      check(32'h3FFFF000, 16'h4000, "R4 carry into exponent");
      check(32'h477FE000, 16'h7BFF, "R5 largest finite");
      check(32'h477FF000, 16'h7C00, "R5 carry to infinity");
      check(32'hC7800000, 16'hFC00, "R5 overflow saturates");
      check(32'h33800000, 16'h0001, "R6 smallest denormal");
      check(32'h38000000, 16'h0200, "R6 half of min normal");
      check(32'h387FF000, 16'h0400, "R6 denormal rounds to normal");
      check(32'h38800000, 16'h0400, "R2 min normal");
      check(32'h33000000, 16'h0000, "R7 below denormal range");
      check(32'h80000001, 16'h8000, "R7 negative input denormal");
      check(32'h7F800000, 16'h7C00, "R8 +inf");
      check(32'hFF800000, 16'hFC00, "R8 -inf");
      check(32'h7FC00000, 16'h7E00, "R9 quiet");
      check(32'hFFC12345, 16'hFE00, "R9 quiet payload dropped");
      check(32'h7F800001, 16'h7C01, "R10 empty payload");
      check(32'hFF801FFF, 16'hFC01, "R10 empty payload neg");
      check(32'h7F802000, 16'h7C01, "R11 payload one");
      check(32'h7FBFE000, 16'h7DFF, "R11 payload kept");

      // mantissa set for the exponent sweep
      mans[0] = 23'h000000; mans[1] = 23'h7FFFFF; mans[2] = 23'h400000;
      mans[3] = 23'h3FFFFF; mans[4] = 23'h001000; mans[5] = 23'h000FFF;
      mans[6] = 23'h001FFF; mans[7] = 23'h002000; mans[8] = 23'h7FF000;
      mans[9] = 23'h7FE000; mans[10] = 23'h7FEFFF; mans[11] = 23'h000001;
      lcg = 32'h1234ABCD;
      for (int k = 12; k < 32; k++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         mans[k] = lcg[30:8];
      end

      for (int s = 0; s < 2; s++) begin
         for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 32; k++) begin
               logic [31:0] f;
               f = {s[0], e[7:0], mans[k]};
               check(f, ref_h(f), tag_of(f));
            end
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule